// File: doc/BRIEF.md
# Accumulator-File ALU with Flag Update Mask

This block is the execution stage of a small accumulator machine with 14-bit instructions and 8-bit data. Each cycle it may accept one instruction word together with the working register value (W), the file operand already read by the surrounding pipeline, and the current Zero, Carry and Digit-Carry flags. It decodes the byte-oriented file operations and the literal operations, computes the 8-bit result, and states where the result goes (W or the file register). It also returns the new flag values and a mask that names the flags this operation writes.

All outputs are registered, so the result appears one clock after the instruction is presented. Flags outside an operation's mask are passed through unchanged from the flag inputs. The caller can therefore write all three flags back unconditionally, or use the mask to gate the write. Opcodes outside the covered set are not executed and produce no valid output. Those include skips, bit operations, branches and returns.

Top module: `acc_alu_unit`

## Requirements
- R1: `out_valid` rises one clock after `in_valid` is high with a covered opcode. During and after reset, all outputs are 0 until the first such instruction.
- R2: Add (opcode bits 13:8 = 000111 with the file operand, or 11111x with the literal in bits 7:0) gives `(operand + W) mod 256`. C is the carry out of bit 7 and DC is the carry out of bit 3. The flag mask is 3'b111, where mask bit 2 = C, bit 1 = DC and bit 0 = Z.
- R3: Subtract (000010 with the file operand, 11110x with the literal) gives `(operand - W) mod 256`. C = 1 exactly when operand >= W, DC = 1 exactly when operand[3:0] >= W[3:0], and the mask is 3'b111.
- R4: The logic operations use mask 3'b001 with Z = (result == 0). AND is 000101 or 111001, OR is 000100 or 111000, XOR is 000110 or 111010, and complement is 001001 with result ~operand.
- R5: Increment (001010), decrement (000011) and move-file (001000) give operand+1, operand-1 and operand (mod 256), each with mask 3'b001.
- R6: Rotate left (001101) gives {operand[6:0], C_in} with new C = operand[7]. Rotate right (001100) gives {C_in, operand[7:1]} with new C = operand[0]. Both use mask 3'b100.
- R7: Swap (001110) exchanges the operand nibbles. Move-W-to-file (000000 with bit 7 = 1) gives W. Move-literal (1100xx) gives the literal. All three use mask 3'b000.
- R8: Clear (000001) gives result 0 and Z = 1 with mask 3'b001. Bit 7 = 1 clears the file register, and bit 7 = 0 clears W.
- R9: For byte operations, `dest_file` equals instruction bit 7. Literal operations always target W (`dest_file` = 0), and the file operand has no effect on them.
- R10: Uncovered opcodes give `out_valid` = 0 on the next cycle. These are 001011, 001111, 01xxxx, 10xxxx, 1101xx, 111011, and 000000 with bit 7 = 0.
- R11: Each flag whose mask bit is 0 is output equal to its flag input from the same instruction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Instruction presented this cycle |
| instr | input | 14 | Instruction word |
| w_val | input | 8 | Working register value |
| f_val | input | 8 | File register operand |
| z_in | input | 1 | Current Zero flag |
| c_in | input | 1 | Current Carry flag |
| dc_in | input | 1 | Current Digit-Carry flag |
| out_valid | output | 1 | Registered result is valid |
| result | output | 8 | Operation result |
| dest_file | output | 1 | 1 = write to file register, 0 = write to W |
| flag_mask | output | 3 | Flags written: bit 2 C, bit 1 DC, bit 0 Z |
| z_out | output | 1 | New Zero flag |
| c_out | output | 1 | New Carry flag |
| dc_out | output | 1 | New Digit-Carry flag |

## Verification
The bench sweeps every covered opcode over a grid of operand and W values, with varied incoming flags, and compares the outputs against integer arithmetic.

- Subtraction at operand = W and at operand = W - 1 tells apart a design that inverts the borrow sense or drops the +1. Such a design gives C wrong on equality, or a result that is off by one.
- Nibble boundaries such as 0x0F + 0x01, and operands with equal low nibbles, catch a DC taken from the wrong bit.
- Rotates run with both carry-in values, which catches a rotate that ignores the carry or shifts in the wrong direction.
- Mask-0 operations run with all flag patterns, which would expose a design that clobbers a flag it should not touch.
- Uncovered opcodes and literal forms with garbage on the file operand show up as spurious valid outputs or wrong results.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;

  localparam int FLAG_W  = 3;
  localparam int MASK_Z  = 0;
  localparam int MASK_DC = 1;
  localparam int MASK_C  = 2;

  typedef enum logic [3:0] {
    K_NONE,
    K_ADD,
    K_SUB,
    K_AND,
    K_IOR,
    K_XOR,
    K_COM,
    K_INC,
    K_DEC,
    K_MOVF,
    K_RLF,
    K_RRF,
    K_SWAP,
    K_CLR,
    K_PASSW,
    K_PASSK
  } alu_kind_e;

  typedef struct packed {
    alu_kind_e          kind;
    logic               use_lit;
    logic               to_file;
    logic               known;
    logic [FLAG_W-1:0]  mask;
  } alu_dec_t;

  function automatic logic [FLAG_W-1:0] mask_of(input alu_kind_e k);
    logic [FLAG_W-1:0] m;
    m = '0;
    case (k)
      K_ADD, K_SUB: m = 3'b111;
      K_AND, K_IOR, K_XOR, K_COM,
      K_INC, K_DEC, K_MOVF, K_CLR: m[MASK_Z] = 1'b1;
      K_RLF, K_RRF: m[MASK_C] = 1'b1;
      default: m = '0;
    endcase
    return m;
  endfunction

endpackage

// File: rtl/acc_alu_decode.sv
module acc_alu_decode
  import acc_alu_pkg::*;
#(
  parameter int INSTR_W = 14,
  parameter int OPC_W   = 6
) (
  input  logic [INSTR_W-1:0] instr,
  output alu_dec_t           dec
);
  localparam int DBIT = INSTR_W - OPC_W - 1;

  logic [OPC_W-1:0] opc;
  logic             dsel;

  assign opc  = instr[INSTR_W-1 -: OPC_W];
  assign dsel = instr[DBIT];

  always_comb begin
    alu_kind_e k;
    logic lit;
    k   = K_NONE;
    lit = 1'b0;
    casez (opc)
      6'b000111: k = K_ADD;
      6'b000010: k = K_SUB;
      6'b000101: k = K_AND;
      6'b000100: k = K_IOR;
      6'b000110: k = K_XOR;
      6'b001001: k = K_COM;
      6'b001010: k = K_INC;
      6'b000011: k = K_DEC;
      6'b001000: k = K_MOVF;
      6'b001101: k = K_RLF;
      6'b001100: k = K_RRF;
      6'b001110: k = K_SWAP;
      6'b000001: k = K_CLR;
      6'b000000: k = dsel ? K_PASSW : K_NONE;
      6'b11111?: begin k = K_ADD;   lit = 1'b1; end
      6'b11110?: begin k = K_SUB;   lit = 1'b1; end
      6'b111001: begin k = K_AND;   lit = 1'b1; end
      6'b111000: begin k = K_IOR;   lit = 1'b1; end
      6'b111010: begin k = K_XOR;   lit = 1'b1; end
      6'b1100??: begin k = K_PASSK; lit = 1'b1; end
      default:   k = K_NONE;
    endcase
    dec.kind    = k;
    dec.use_lit = lit;
    dec.known   = (k != K_NONE);
    dec.to_file = (k != K_NONE) && !lit && dsel;
    dec.mask    = mask_of(k);
  end

  // R9: literal-class opcodes must never be routed to the file register
  always_comb begin
    if (opc[OPC_W-1:OPC_W-2] == 2'b11 && dec.known)
      assert_lit_to_w_R9: assert (!dec.to_file);
  end

endmodule

// File: rtl/acc_alu_core.sv
module acc_alu_core
  import acc_alu_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  alu_kind_e         kind,
  input  logic [DATA_W-1:0] w,
  input  logic [DATA_W-1:0] a,
  input  logic              c_cur,
  output logic [DATA_W-1:0] res,
  output logic              c_new,
  output logic              dc_new
);
  localparam int HALF = DATA_W / 2;

  logic              is_sub;
  logic [DATA_W-1:0] addend;
  logic [DATA_W:0]   sum_full;
  logic [HALF:0]     sum_low;
  logic [DATA_W-1:0] swapped;

  assign is_sub   = (kind == K_SUB);
  assign addend   = is_sub ? ~w : w;
  assign sum_full = {1'b0, a} + {1'b0, addend} + {{DATA_W{1'b0}}, is_sub};
  assign sum_low  = {1'b0, a[HALF-1:0]} + {1'b0, addend[HALF-1:0]}
                  + {{HALF{1'b0}}, is_sub};

  generate
    if (DATA_W % 2 == 0) begin : g_even_swap
      assign swapped = {a[HALF-1:0], a[DATA_W-1:HALF]};
    end else begin : g_odd_swap
      assign swapped = {a[HALF-1:0], a[DATA_W-1:HALF]};
    end
  endgenerate

  always_comb begin
    res    = a;
    c_new  = c_cur;
    dc_new = sum_low[HALF];
    case (kind)
      K_ADD, K_SUB: begin
        res   = sum_full[DATA_W-1:0];
        c_new = sum_full[DATA_W];
      end
      K_AND:   res = a & w;
      K_IOR:   res = a | w;
      K_XOR:   res = a ^ w;
      K_COM:   res = ~a;
      K_INC:   res = a + {{(DATA_W-1){1'b0}}, 1'b1};
      K_DEC:   res = a - {{(DATA_W-1){1'b0}}, 1'b1};
      K_MOVF:  res = a;
      K_RLF: begin
        res   = {a[DATA_W-2:0], c_cur};
        c_new = a[DATA_W-1];
      end
      K_RRF: begin
        res   = {c_cur, a[DATA_W-1:1]};
        c_new = a[0];
      end
      K_SWAP:  res = swapped;
      K_CLR:   res = '0;
      K_PASSW: res = w;
      K_PASSK: res = a;
      default: res = a;
    endcase
  end

  // R8: clear must yield an all-zero result
  always_comb begin
    if (kind == K_CLR)
      assert_clear_zero_R8: assert (res == '0);
  end

  // R6: rotate-left carry out comes from the top operand bit
  always_comb begin
    if (kind == K_RLF)
      assert_rlf_carry_R6: assert (c_new == a[DATA_W-1]);
  end

endmodule

// File: rtl/acc_alu_flags.sv
module acc_alu_flags
  import acc_alu_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic [FLAG_W-1:0] mask,
  input  logic [DATA_W-1:0] res,
  input  logic              c_calc,
  input  logic              dc_calc,
  input  logic              z_cur,
  input  logic              c_cur,
  input  logic              dc_cur,
  output logic              z_nxt,
  output logic              c_nxt,
  output logic              dc_nxt
);
  assign z_nxt  = mask[MASK_Z]  ? (res == '0) : z_cur;
  assign c_nxt  = mask[MASK_C]  ? c_calc      : c_cur;
  assign dc_nxt = mask[MASK_DC] ? dc_calc     : dc_cur;
endmodule

// File: rtl/acc_alu_unit.sv
module acc_alu_unit
  import acc_alu_pkg::*;
#(
  parameter int INSTR_W = 14,
  parameter int DATA_W  = 8,
  parameter int OPC_W   = 6
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               in_valid,
  input  logic [INSTR_W-1:0] instr,
  input  logic [DATA_W-1:0]  w_val,
  input  logic [DATA_W-1:0]  f_val,
  input  logic               z_in,
  input  logic               c_in,
  input  logic               dc_in,
  output logic               out_valid,
  output logic [DATA_W-1:0]  result,
  output logic               dest_file,
  output logic [FLAG_W-1:0]  flag_mask,
  output logic               z_out,
  output logic               c_out,
  output logic               dc_out
);
  alu_dec_t          dec;
  logic [DATA_W-1:0] operand;
  logic [DATA_W-1:0] res_c;
  logic              c_calc, dc_calc;
  logic              z_nxt, c_nxt, dc_nxt;

  acc_alu_decode #(.INSTR_W(INSTR_W), .OPC_W(OPC_W)) u_dec (
    .instr (instr),
    .dec   (dec)
  );

  assign operand = dec.use_lit ? instr[DATA_W-1:0] : f_val;

  acc_alu_core #(.DATA_W(DATA_W)) u_core (
    .kind   (dec.kind),
    .w      (w_val),
    .a      (operand),
    .c_cur  (c_in),
    .res    (res_c),
    .c_new  (c_calc),
    .dc_new (dc_calc)
  );

  acc_alu_flags #(.DATA_W(DATA_W)) u_flags (
    .mask    (dec.mask),
    .res     (res_c),
    .c_calc  (c_calc),
    .dc_calc (dc_calc),
    .z_cur   (z_in),
    .c_cur   (c_in),
    .dc_cur  (dc_in),
    .z_nxt   (z_nxt),
    .c_nxt   (c_nxt),
    .dc_nxt  (dc_nxt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      result    <= '0;
      dest_file <= 1'b0;
      flag_mask <= '0;
      z_out     <= 1'b0;
      c_out     <= 1'b0;
      dc_out    <= 1'b0;
    end else begin
      out_valid <= in_valid && dec.known;
      if (in_valid && dec.known) begin
        result    <= res_c;
        dest_file <= dec.to_file;
        flag_mask <= dec.mask;
        z_out     <= z_nxt;
        c_out     <= c_nxt;
        dc_out    <= dc_nxt;
      end
    end
  end

  assert_valid_follows_R1: assert property (@(posedge clk) disable iff (rst)
    (in_valid && dec.known) |=> out_valid);

  assert_uncovered_drop_R10: assert property (@(posedge clk) disable iff (rst)
    (!in_valid || !dec.known) |=> !out_valid);

  assert_carry_hold_R11: assert property (@(posedge clk) disable iff (rst)
    (in_valid && dec.known && !dec.mask[MASK_C]) |=> (c_out == $past(c_in)));

  assert_dc_hold_R11: assert property (@(posedge clk) disable iff (rst)
    (in_valid && dec.known && !dec.mask[MASK_DC]) |=> (dc_out == $past(dc_in)));

  assert_zero_tracks_R4: assert property (@(posedge clk) disable iff (rst)
    (out_valid && flag_mask[MASK_Z]) |-> (z_out == (result == '0)));

endmodule

// File: tb/tb_acc_alu_unit.sv
module tb_acc_alu_unit;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst;
  logic        in_valid;
  logic [13:0] instr;
  logic [7:0]  w_val, f_val;
  logic        z_in, c_in, dc_in;
  logic        out_valid, dest_file, z_out, c_out, dc_out;
  logic [7:0]  result;
  logic [2:0]  flag_mask;

  int total = 0;
  int bad   = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  acc_alu_unit dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .instr(instr),
    .w_val(w_val), .f_val(f_val), .z_in(z_in), .c_in(c_in), .dc_in(dc_in),
    .out_valid(out_valid), .result(result), .dest_file(dest_file),
    .flag_mask(flag_mask), .z_out(z_out), .c_out(c_out), .dc_out(dc_out)
  );

  // Reference: {valid, res[7:0], dest, mask[2:0], c, dc, z}
  function automatic logic [15:0] model(input logic [13:0] ins, input logic [7:0] w,
                                        input logic [7:0] f, input logic ci,
                                        input logic dci, input logic zi);
    int a, wi, s, r;
    logic v, d, c, dc, z;
    logic [2:0] m;
    logic [5:0] op;
    op = ins[13:8];
    d  = ins[7];
    wi = int'(w);
    a  = (op[5:4] == 2'b11) ? int'(ins[7:0]) : int'(f);
    v = 1'b1; m = 3'b000; r = a; c = ci; dc = dci;
    if (op[5:4] == 2'b11) d = 1'b0;
    casez (op)
      6'b000111, 6'b11111?: begin
        s = a + wi; r = s % 256; c = (s > 255);
        dc = ((a % 16) + (wi % 16)) > 15; m = 3'b111; end
      6'b000010, 6'b11110?: begin
        s = a - wi; r = (s + 256) % 256; c = (a >= wi);
        dc = ((a % 16) >= (wi % 16)); m = 3'b111; end
      6'b000101, 6'b111001: begin r = a & wi; m = 3'b001; end
      6'b000100, 6'b111000: begin r = a | wi; m = 3'b001; end
      6'b000110, 6'b111010: begin r = a ^ wi; m = 3'b001; end
      6'b001001: begin r = 255 - a; m = 3'b001; end
      6'b001010: begin r = (a + 1) % 256; m = 3'b001; end
      6'b000011: begin r = (a + 255) % 256; m = 3'b001; end
      6'b001000: begin r = a; m = 3'b001; end
      6'b001101: begin r = ((a * 2) % 256) + int'(ci); c = (a >= 128); m = 3'b100; end
      6'b001100: begin r = (a / 2) + (ci ? 128 : 0); c = a[0]; m = 3'b100; end
      6'b001110: begin r = (a % 16) * 16 + a / 16; end
      6'b000001: begin r = 0; m = 3'b001; end
      6'b000000: begin if (d) r = wi; else v = 1'b0; end
      6'b1100??: begin r = a; end
      default: v = 1'b0;
    endcase
    z = m[0] ? (r == 0) : zi;
    return {v, 8'(r), d, m, c, dc, z};
  endfunction

  task automatic check_now(input logic [15:0] exp, input string req);
    total++;
    if (out_valid !== exp[15]) begin
      bad++;
      $display("FAIL %s valid ins=%h act=%b exp=%b", req, instr, out_valid, exp[15]);
    end else if (exp[15] && {result, dest_file, flag_mask, c_out, dc_out, z_out} !== exp[14:0]) begin
      bad++;
      $display("FAIL %s ins=%h w=%h f=%h act=%h exp=%h", req, instr, w_val, f_val,
               {result, dest_file, flag_mask, c_out, dc_out, z_out}, exp[14:0]);
    end
  endtask

  // Drive at a negedge; result is registered at the next posedge, sampled at the following negedge.
  task automatic run(input logic [13:0] ins, input logic [7:0] w, input logic [7:0] f,
                     input logic [2:0] fl, input string req);
    logic [15:0] exp;
    in_valid = 1'b1; instr = ins; w_val = w; f_val = f;
    {c_in, dc_in, z_in} = fl;
    exp = model(ins, w, f, fl[2], fl[1], fl[0]);
    @(negedge clk);
    check_now(exp, req);
  endtask

  function automatic logic [5:0] sweep_opc(input int i, input logic alt);
    case (i)
      0:  return 6'b000111;  1:  return 6'b000010;  2:  return 6'b000101;
      3:  return 6'b000100;  4:  return 6'b000110;  5:  return 6'b001001;
      6:  return 6'b001010;  7:  return 6'b000011;  8:  return 6'b001000;
      9:  return 6'b001101;  10: return 6'b001100;  11: return 6'b001110;
      12: return {5'b11111, alt}; 13: return {5'b11110, alt};
      14: return 6'b111001;  15: return 6'b111000;  16: return 6'b111010;
      default: return {4'b1100, alt, ~alt};
    endcase
  endfunction

  function automatic string req_of(input int i);
    case (i)
      0, 12: return "R2";
      1, 13: return "R3";
      2, 3, 4, 5, 14, 15, 16: return "R4";
      6, 7, 8: return "R5";
      9, 10: return "R6";
      default: return "R7";
    endcase
  endfunction

  initial begin
    repeat (190000) @(posedge clk);
    bad++;
    $display("FAIL R1 watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst = 1'b1; in_valid = 1'b0; instr = '0; w_val = '0; f_val = '0;
    z_in = 1'b1; c_in = 1'b1; dc_in = 1'b1;
    repeat (3) @(negedge clk);
    // R1: reset state
    total++;
    if ({out_valid, result, dest_file, flag_mask, z_out, c_out, dc_out} !== '0) begin
      bad++; $display("FAIL R1 reset outputs act=%b exp=0", out_valid);
    end
    rst = 1'b0;
    // R1: no valid without in_valid
    in_valid = 1'b0; instr = 14'h0700;
    @(negedge clk);
    total++;
    if (out_valid !== 1'b0) begin bad++; $display("FAIL R1 idle act=%b exp=0", out_valid); end

    // Directed corners
    run(14'h0780, 8'h01, 8'h0F, 3'b000, "R2");  // DC from nibble
    run(14'h0700, 8'h01, 8'hFF, 3'b000, "R2");  // C and Z
    run(14'h0280, 8'h5A, 8'h5A, 3'b000, "R3");  // equal: C=1 DC=1 Z=1
    run(14'h0200, 8'h01, 8'h00, 3'b111, "R3");  // borrow
    run(14'h3C05, 8'h06, 8'h00, 3'b110, "R3");  // literal minus W borrow
    run(14'h0D80, 8'h00, 8'h80, 3'b100, "R6");
    run(14'h0C00, 8'h00, 8'h01, 3'b000, "R6");
    run(14'h0180, 8'h33, 8'h44, 3'b000, "R8");  // clear file
    run(14'h0100, 8'h33, 8'h44, 3'b111, "R8");  // clear W
    run(14'h0080, 8'hA5, 8'h11, 3'b101, "R7");  // move W to file

    // Sweep covered opcodes over an operand/W grid
    for (int oi = 0; oi < 18; oi++) begin
      for (int ai = 0; ai < 256; ai += 3) begin
        for (int wi = 0; wi < 256; wi += 5) begin
          int n;
          logic [5:0] op;
          n  = ai * 7 + wi;
          op = sweep_opc(oi, n[2]);
          if (op[5:4] == 2'b11)
            run({op, 8'(ai)}, 8'(wi), 8'(ai ^ 8'h5A ^ wi), 3'(n >> 1), {req_of(oi), "/R9"});
          else
            run({op, n[0], 7'h2A}, 8'(wi), 8'(ai), 3'(n >> 1), {req_of(oi), "/R9/R11"});
        end
      end
    end

    // Clear and move-W-to-file across values and flags
    for (int ai = 0; ai < 256; ai += 1) begin
      run({6'b000001, ai[0], 7'h11}, 8'(ai), 8'(255 - ai), 3'(ai), "R8");
      run({6'b000000, 1'b1, 7'(ai)}, 8'(ai), 8'(ai + 3), 3'(ai >> 2), "R7/R11");
    end

    // Uncovered opcodes
    for (int k = 0; k < 64; k++) begin
      run({6'b001011, k[0], 7'(k)}, 8'(k), 8'(k), 3'b000, "R10");
      run({6'b001111, k[0], 7'(k)}, 8'(k), 8'(k), 3'b000, "R10");
      run({2'b01, 4'(k), 8'(k)}, 8'(k), 8'(k), 3'b000, "R10");
      run({2'b10, 4'(k), 8'(k)}, 8'(k), 8'(k), 3'b000, "R10");
      run({4'b1101, 2'(k), 8'(k)}, 8'(k), 8'(k), 3'b000, "R10");
      run({6'b111011, 8'(k)}, 8'(k), 8'(k), 3'b000, "R10");
      run({6'b000000, 1'b0, 7'(k)}, 8'(k), 8'(k), 3'b000, "R10");
    end

    // R1: in_valid low after a valid op drops out_valid
    in_valid = 1'b0; instr = 14'h0700;
    @(negedge clk);
    total++;
    if (out_valid !== 1'b0) begin bad++; $display("FAIL R1 drop act=%b exp=0", out_valid); end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule